// File: doc/BRIEF.md
# Flat Page-Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one entry from a flat page table in memory. Software loads a table base register. Writing that register moves all later walks to a new address space. A requester hands over a virtual address together with an access kind (data read, data write or instruction fetch). The block computes where the matching entry lives, issues a single read on a plain valid/ready memory request port, and waits for the read data. It then reports one of two results: a translated physical address with the entry's rights, or a fault carrying a cause code and the offending virtual address.

Pages are 4 KB and entries are 4 bytes wide. The upper twenty bits of the virtual address select the entry, and the low twelve bits are carried straight into the physical address. The block handles one walk at a time. It does not fix missing pages or rights violations; it only reports them, so that software can act on them.

Top module: `pt_walker`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, req_ready_o is 1, mem_req_valid_o is 0 and rsp_valid_o is 0.
- R2: The entry address on mem_req_addr_o equals the base register with its two low bits cleared, plus the virtual page number (vaddr[31:12]) times 4. The base value used is the one held when the request is accepted. A base write made during a walk changes only the walks accepted after it.
- R3: Each accepted request produces exactly one memory read. mem_req_valid_o stays high with an unchanged address until mem_req_ready_i is seen high, and it is low in the following cycle.
- R4: req_ready_o drops in the cycle after a request is accepted. It stays low through the cycle in which rsp_valid_o is high, and it returns to 1 in the cycle after that.
- R5: Entry layout: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bits 31:12 physical page number. On success, rsp_paddr_o = {entry[31:12], vaddr[11:0]}, rsp_perm_o = entry[3:1] (bit 0 read, bit 1 write, bit 2 execute), rsp_fault_o = 0 and rsp_cause_o = 2'b00.
- R6: An entry with bit 0 clear gives rsp_fault_o = 1 with rsp_cause_o = 2'b01, whatever its other bits hold. This check takes precedence over the rights check.
- R7: Access kind codes are 2'b00 read, 2'b01 write and 2'b10 fetch. Each one needs entry bit 1, 2 or 3 respectively. If that bit is clear, or if the kind is 2'b11, the result is rsp_fault_o = 1 with rsp_cause_o = 2'b10.
- R8: On a fault, rsp_paddr_o and rsp_perm_o are 0 and rsp_fault_vaddr_o holds the request's virtual address. On success, rsp_fault_vaddr_o is 0.
- R9: rsp_valid_o is a one-cycle pulse. It rises in the cycle after the clock edge that samples mem_rsp_valid_i high while a read is outstanding, and it is never high before that.
- R10: A pulse on mem_rsp_valid_i while no read is outstanding is ignored: no response is produced and req_ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load the table base register |
| base_wdata_i | input | 32 | New table base |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 32 | Entry contents |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_paddr_o | output | 32 | Physical address (0 on fault) |
| rsp_perm_o | output | 3 | Rights {x, w, r} of the entry (0 on fault) |
| rsp_fault_o | output | 1 | Walk faulted |
| rsp_cause_o | output | 2 | 00 none, 01 not present, 10 rights violation |
| rsp_fault_vaddr_o | output | 32 | Faulting virtual address (0 on success) |

## Verification
A base register or captured address that is corrupted shows up on mem_req_addr_o one cycle after acceptance, before memory has answered. Comparing that address with the bench's own base-plus-index sum therefore catches it at the earliest point. A control sequencer in the wrong state shows up as a ready that stays low, a read that repeats, or a result pulse that arrives early or lasts two cycles. Each of these is visible within the cycle after the handshake that should have moved it. Errors in decoding or the rights check appear only in the single result cycle. For that reason every access kind is run against entries that grant and deny it, and against invalid entries with every rights bit set.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_ABSENT  = 2'b01,
    CAUSE_RIGHTS  = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } walk_st_e;

  localparam int unsigned PTE_V_BIT = 0;
  localparam int unsigned PTE_R_BIT = 1;
  localparam int unsigned N_RIGHTS  = 3;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic mem_req_valid_o,
  output logic capture_o,
  output logic rsp_valid_o
);

  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i)     st_d = ST_MREQ;
      ST_MREQ:  if (mem_req_ready_i) st_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid_i) st_d = ST_RESP;
      ST_RESP:                       st_d = ST_IDLE;
      default:                       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign accept_o        = (st_q == ST_IDLE) && req_valid_i;
  assign mem_req_valid_o = (st_q == ST_MREQ);
  // stray responses outside MWAIT are dropped
  assign capture_o       = (st_q == ST_MWAIT) && mem_rsp_valid_i;
  assign rsp_valid_o     = (st_q == ST_RESP);

  AST_SINGLE_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R4
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o)); // R9
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o); // R3
  AST_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_valid_i) |=> !rsp_valid_o); // R10

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic [PTE_W-1:0]    pte_i,
  input  logic [1:0]          acc_i,
  input  logic [VA_W-1:0]     vaddr_i,
  output logic [PA_W-1:0]     paddr_o,
  output logic [N_RIGHTS-1:0] perm_o,
  output logic                fault_o,
  output cause_e              cause_o,
  output logic [VA_W-1:0]     fault_vaddr_o
);

  localparam int unsigned PPN_W = PA_W - OFS_W;

  logic [N_RIGHTS-1:0] rights;
  logic [N_RIGHTS-1:0] granted;
  logic                allowed;

  assign rights = pte_i[PTE_R_BIT +: N_RIGHTS];

  // one grant line per access kind; reserved kind matches none
  for (genvar k = 0; k < N_RIGHTS; k++) begin : g_grant
    assign granted[k] = (acc_i == 2'(k)) && rights[k];
  end
  assign allowed = |granted;

  always_comb begin
    paddr_o       = '0;
    perm_o        = '0;
    fault_o       = 1'b1;
    cause_o       = CAUSE_NONE;
    fault_vaddr_o = vaddr_i;
    if (!pte_i[PTE_V_BIT]) begin
      cause_o = CAUSE_ABSENT;
    end else if (!allowed) begin
      cause_o = CAUSE_RIGHTS;
    end else begin
      fault_o       = 1'b0;
      paddr_o       = {pte_i[PTE_W-1 -: PPN_W], vaddr_i[OFS_W-1:0]};
      perm_o        = rights;
      fault_vaddr_o = '0;
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned OFS_W  = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                base_we_i,
  input  logic [ADDR_W-1:0]   base_wdata_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_vaddr_i,
  input  logic [1:0]          req_acc_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [ADDR_W-1:0]   mem_req_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [PTE_W-1:0]    mem_rsp_data_i,
  output logic                rsp_valid_o,
  output logic [PA_W-1:0]     rsp_paddr_o,
  output logic [N_RIGHTS-1:0] rsp_perm_o,
  output logic                rsp_fault_o,
  output logic [1:0]          rsp_cause_o,
  output logic [VA_W-1:0]     rsp_fault_vaddr_o
);

  localparam int unsigned PTE_LOG2 = $clog2(PTE_W / 8);
  localparam int unsigned VPN_W    = VA_W - OFS_W;

  logic [ADDR_W-1:PTE_LOG2] base_q;
  logic [ADDR_W-1:0]        base_al, ent_addr, addr_q;
  logic [VA_W-1:0]          vaddr_q;
  logic [1:0]               acc_q;
  logic                     accept, capture;

  logic [PA_W-1:0]     chk_paddr;
  logic [N_RIGHTS-1:0] chk_perm;
  logic                chk_fault;
  cause_e              chk_cause;
  logic [VA_W-1:0]     chk_fva;

  ptw_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .capture_o       (capture),
    .rsp_valid_o     (rsp_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_we_i) base_q <= base_wdata_i[ADDR_W-1:PTE_LOG2];
  end

  assign base_al  = {base_q, {PTE_LOG2{1'b0}}};
  assign ent_addr = base_al + (ADDR_W'(req_vaddr_i[VA_W-1 -: VPN_W]) << PTE_LOG2);

  // address fixed at acceptance; later base writes only affect later walks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      vaddr_q <= '0;
      acc_q   <= '0;
    end else if (accept) begin
      addr_q  <= ent_addr;
      vaddr_q <= req_vaddr_i;
      acc_q   <= req_acc_i;
    end
  end

  assign mem_req_addr_o = addr_q;

  ptw_pte_check #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .PTE_W (PTE_W),
    .OFS_W (OFS_W)
  ) u_check (
    .pte_i         (mem_rsp_data_i),
    .acc_i         (acc_q),
    .vaddr_i       (vaddr_q),
    .paddr_o       (chk_paddr),
    .perm_o        (chk_perm),
    .fault_o       (chk_fault),
    .cause_o       (chk_cause),
    .fault_vaddr_o (chk_fva)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_paddr_o       <= '0;
      rsp_perm_o        <= '0;
      rsp_fault_o       <= 1'b0;
      rsp_cause_o       <= CAUSE_NONE;
      rsp_fault_vaddr_o <= '0;
    end else if (capture) begin
      rsp_paddr_o       <= chk_paddr;
      rsp_perm_o        <= chk_perm;
      rsp_fault_o       <= chk_fault;
      rsp_cause_o       <= chk_cause;
      rsp_fault_vaddr_o <= chk_fva;
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[PTE_LOG2-1:0] == '0)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R3
  AST_OFS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFS_W-1:0] == vaddr_q[OFS_W-1:0])); // R5
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0 && rsp_perm_o == '0
                                      && rsp_cause_o != 2'b00 && rsp_fault_vaddr_o == vaddr_q)); // R8
  AST_OK_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_cause_o == 2'b00 && rsp_fault_vaddr_o == '0)); // R8

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 11;

  // {vaddr, acc, pte, req_lat, rsp_lat}
  localparam logic [31:0] VEC_VA  [N_VEC] = '{
    32'h0000_5ABC, 32'h0000_6010, 32'h0000_6FFC, 32'h0000_1000, 32'h0000_2004,
    32'h0000_3123, 32'h0000_0000, 32'h0000_4444, 32'h0000_7008, 32'h0007_FFFF,
    32'h0001_0800};
  localparam logic [1:0]  VEC_ACC [N_VEC] = '{
    2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b10};
  localparam logic [31:0] VEC_PTE [N_VEC] = '{
    32'h1234_5003, 32'hABCD_E003, 32'hABCD_E007, 32'h0040_0009, 32'h0040_0007,
    32'hFFFF_F00E, 32'h0000_0000, 32'h1111_100F, 32'h2222_2009, 32'hFFFF_F00F,
    32'h0BEE_F00B};
  localparam int VEC_RQL [N_VEC] = '{0, 1, 3, 0, 2, 1, 0, 2, 3, 1, 0};
  localparam int VEC_RSL [N_VEC] = '{0, 2, 1, 3, 0, 1, 2, 0, 3, 1, 2};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic [2:0]  rsp_perm_o;
  logic        rsp_fault_o;
  logic [1:0]  rsp_cause_o;
  logic [31:0] rsp_fault_vaddr_o;

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] mem [256];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .base_we_i         (base_we_i),
    .base_wdata_i      (base_wdata_i),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .req_vaddr_i       (req_vaddr_i),
    .req_acc_i         (req_acc_i),
    .mem_req_valid_o   (mem_req_valid_o),
    .mem_req_ready_i   (mem_req_ready_i),
    .mem_req_addr_o    (mem_req_addr_o),
    .mem_rsp_valid_i   (mem_rsp_valid_i),
    .mem_rsp_data_i    (mem_rsp_data_i),
    .rsp_valid_o       (rsp_valid_o),
    .rsp_paddr_o       (rsp_paddr_o),
    .rsp_perm_o        (rsp_perm_o),
    .rsp_fault_o       (rsp_fault_o),
    .rsp_cause_o       (rsp_cause_o),
    .rsp_fault_vaddr_o (rsp_fault_vaddr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_result(input logic [31:0] pte, input logic [1:0] acc,
                               input logic [31:0] va, output logic [31:0] pa,
                               output logic [2:0] perm, output logic flt,
                               output logic [1:0] cause, output logic [31:0] fva);
    logic has;
    case (acc)
      2'b00:   has = pte[1];
      2'b01:   has = pte[2];
      2'b10:   has = pte[3];
      default: has = 1'b0;
    endcase
    pa = '0; perm = '0; flt = 1'b1; fva = va;
    if (!pte[0])   cause = 2'b01;
    else if (!has) cause = 2'b10;
    else begin
      cause = 2'b00; flt = 1'b0; fva = '0;
      pa = {pte[31:12], va[11:0]};
      perm = pte[3:1];
    end
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = v;
    @(negedge clk_i);
    base_we_i = 1'b0;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [1:0] acc,
                         input int rql, input int rsl, input logic [31:0] eff_base,
                         input bit mid_wr, input logic [31:0] mid_val);
    logic [31:0] exp_addr, a0, pte, e_pa, e_fva;
    logic [2:0]  e_perm;
    logic        e_flt;
    logic [1:0]  e_cause;
    exp_addr = {eff_base[31:2], 2'b00} + ({12'h0, va[31:12]} << 2);
    chk(req_ready_o == 1'b1, "R4", "ready before walk", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_vaddr_i = va; req_acc_i = acc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R4", "ready after accept", 32'(req_ready_o), 32'd0);
    base_we_i = mid_wr; base_wdata_i = mid_val;
    @(negedge clk_i);
    base_we_i = 1'b0;
    a0 = mem_req_addr_o;
    chk(mem_req_valid_o == 1'b1, "R3", "read issued", 32'(mem_req_valid_o), 32'd1);
    chk(a0 == exp_addr, "R2", "entry address", a0, exp_addr);
    for (int i = 0; i < rql; i++) begin
      @(negedge clk_i);
      chk(mem_req_valid_o && mem_req_addr_o == a0, "R3", "request held",
          mem_req_addr_o, a0);
    end
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    chk(mem_req_valid_o == 1'b0, "R3", "single read", 32'(mem_req_valid_o), 32'd0);
    for (int i = 0; i < rsl; i++) begin
      chk(rsp_valid_o == 1'b0, "R9", "no early response", 32'(rsp_valid_o), 32'd0);
      chk(req_ready_o == 1'b0, "R4", "busy during wait", 32'(req_ready_o), 32'd0);
      @(negedge clk_i);
    end
    pte = mem[a0[9:2]];
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = pte;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; mem_rsp_data_i = 32'hDEAD_BEEF;
    expect_result(pte, acc, va, e_pa, e_perm, e_flt, e_cause, e_fva);
    chk(rsp_valid_o == 1'b1, "R9", "response pulse", 32'(rsp_valid_o), 32'd1);
    chk(req_ready_o == 1'b0, "R4", "busy in response", 32'(req_ready_o), 32'd0);
    chk(rsp_fault_o == e_flt, e_cause == 2'b01 ? "R6" : (e_cause == 2'b10 ? "R7" : "R5"),
        "fault flag", 32'(rsp_fault_o), 32'(e_flt));
    chk(rsp_cause_o == e_cause, e_cause == 2'b01 ? "R6" : "R7", "cause",
        32'(rsp_cause_o), 32'(e_cause));
    chk(rsp_paddr_o == e_pa, e_flt ? "R8" : "R5", "paddr", rsp_paddr_o, e_pa);
    chk(rsp_perm_o == e_perm, e_flt ? "R8" : "R5", "perm", 32'(rsp_perm_o), 32'(e_perm));
    chk(rsp_fault_vaddr_o == e_fva, "R8", "fault vaddr", rsp_fault_vaddr_o, e_fva);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R9", "pulse ends", 32'(rsp_valid_o), 32'd0);
    chk(req_ready_o == 1'b1, "R4", "ready again", 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {20'(i * 7 + 3), 12'h00F};

    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 32'(req_ready_o), 32'd1);
    chk(mem_req_valid_o == 1'b0, "R1", "mem idle in reset", 32'(mem_req_valid_o), 32'd0);
    chk(rsp_valid_o == 1'b0, "R1", "rsp idle in reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1", "after reset",
        {29'd0, req_ready_o, mem_req_valid_o, rsp_valid_o}, 32'd4);

    // table walk with base 0
    for (int v = 0; v < N_VEC; v++) begin
      mem[VEC_VA[v][19:12]] = VEC_PTE[v];
      do_walk(VEC_VA[v], VEC_ACC[v], VEC_RQL[v], VEC_RSL[v], 32'h0, 1'b0, 32'h0);
    end

    // R10: stray response while idle
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hFFFF_F00F;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b0, "R10", "stray ignored", 32'(rsp_valid_o), 32'd0);
    chk(req_ready_o == 1'b1, "R10", "still ready", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0 && mem_req_valid_o == 1'b0, "R10", "no walk started",
        32'(rsp_valid_o), 32'd0);

    // R2: switch base (low bits must be dropped)
    mem[128 + 5] = 32'h0ABC_D003;
    mem[5]       = 32'h0111_1003;
    write_base(32'h0000_0203);
    do_walk(32'h0000_5678, 2'b00, 1, 1, 32'h0000_0200, 1'b0, 32'h0);
    chk(1'b1, "R2", "second space walked", 32'h0, 32'h0);

    // R2: base write during a walk only affects the next walk
    do_walk(32'h0000_5010, 2'b00, 2, 1, 32'h0000_0200, 1'b1, 32'h0000_0000);
    do_walk(32'h0000_5010, 2'b00, 0, 0, 32'h0000_0000, 1'b0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule